// File: doc/BRIEF.md
# PFD Digital Lock Detector

This block decides whether a fractional-N synthesizer loop is in lock. Once per phase-detector comparison, an upstream measurement stage presents a strobe together with the magnitude of the phase error, already quantized to whole nanoseconds. The detector counts an unbroken run of strobed comparisons whose error is small. When the run reaches the selected length, it raises a registered lock flag.

The thresholds are asymmetric, which gives hysteresis. An error under 15 ns counts toward acquiring lock. Once lock is held, only an error above 30 ns drops it, so moderate jitter in a settled loop does not make the flag chatter. A precision input picks the run length: 24 comparisons for a quick indication or 40 for a more trustworthy one. A new-channel strobe, which the register file issues whenever the divider is rewritten, clears the flag and the run. So does a power-down level. Lock must then be earned again from zero.

Top module: `pfd_lock_monitor`

## Requirements
- R1: A strobed sample counts as good only when its error value is below 15; a value of 14 counts, and a value of 15 does not.
- R2: While unlocked, the lock output goes high on the clock edge that accepts the Nth consecutive good strobed sample, where N is 24 when `precSel` is 0 and 40 when `precSel` is 1. After N−1 such samples it is still low.
- R3: While locked, a strobed sample with an error above 30 clears the lock output on that clock edge.
- R4: A `newChan` pulse clears the lock output and the run count on its clock edge. This takes priority over any strobed sample in the same cycle.
- R5: While `pwrDown` is high, the lock output is held low and the run count is held at zero, whatever samples arrive.
- R6: While locked, strobed samples with errors of 30 or below, including the values 15 to 30, leave the lock output high.
- R7: While unlocked, a strobed sample with an error of 15 or more resets the run count to zero.
- R8: After lock is lost, lock returns only after a complete new run of the selected length.
- R9: Cycles with `errValid` low neither advance nor break a run.
- R10: An active-low `rstN` asynchronously clears the lock output and the run count. The run count never exceeds the longer run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrDown | input | 1 | Power-down level; holds the detector cleared |
| newChan | input | 1 | One-cycle strobe issued on a channel reprogram |
| precSel | input | 1 | Run-length select: 0 for 24 samples, 1 for 40 |
| errValid | input | 1 | Marks a cycle that carries a phase-error sample |
| errNs | input | ERR_W (8) | Phase-error magnitude in nanoseconds |
| lockOut | output | 1 | Registered lock flag |

## Verification
Two functions can fall in the same cycle: a clearing event (`newChan` or `pwrDown`), and either the sample that completes a run or a sample that would drop lock. The bench drives 23 good samples and then presents the 24th in the same cycle as `newChan`. It judges the result twice. First, the lock output must stay low on that edge. Second, the run must really have been cleared, so the next 23 good samples must still leave lock low and only the 24th may raise it. Power-down is also held across a stream of good samples, and lock must stay low until a full run follows the release.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  typedef struct packed {
    logic clrRun;
    logic incRun;
    logic setLock;
    logic clrLock;
  } ldStrobes_t;
endpackage

// File: rtl/lock_det_datapath.sv
module lock_det_datapath
  import lock_det_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int ACQ_NS    = 15,
  parameter int LOSE_NS   = 30,
  parameter int SHORT_RUN = 24,
  parameter int LONG_RUN  = 40,
  localparam int CNT_W    = $clog2(LONG_RUN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ERR_W-1:0] errNs,
  input  logic             precSel,
  input  ldStrobes_t       stb,
  output logic             isSmall,
  output logic             isLarge,
  output logic             runReached,
  output logic [CNT_W-1:0] runCnt
);
  localparam logic [ERR_W-1:0] ACQ_LIM  = ERR_W'(ACQ_NS);
  localparam logic [ERR_W-1:0] LOSE_LIM = ERR_W'(LOSE_NS);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_RUN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_RUN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(LONG_RUN);

  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    isSmall    = errNs < ACQ_LIM;
    isLarge    = errNs > LOSE_LIM;
    lastIdx    = precSel ? LONG_LAST : SHORT_LAST;
    runReached = runCnt >= lastIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (stb.clrRun) begin
      runCnt <= '0;
    end else if (stb.incRun && runCnt != CNT_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lock_det_control.sv
module lock_det_control
  import lock_det_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  logic       newChan,
  input  logic       errValid,
  input  logic       isSmall,
  input  logic       isLarge,
  input  logic       runReached,
  output ldStrobes_t stb,
  output logic       lockQ
);
  logic kill;
  logic goodUnlocked;

  always_comb begin
    kill         = pwrDown | newChan;
    goodUnlocked = errValid & ~lockQ & isSmall;
    stb.clrRun   = kill | (errValid & (lockQ | ~isSmall | runReached));
    stb.incRun   = ~kill & goodUnlocked & ~runReached;
    stb.setLock  = ~kill & goodUnlocked & runReached;
    stb.clrLock  = kill | (errValid & lockQ & isLarge);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
    end else if (stb.clrLock) begin
      lockQ <= 1'b0;
    end else if (stb.setLock) begin
      lockQ <= 1'b1;
    end
  end
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
  import lock_det_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int ACQ_NS    = 15,
  parameter int LOSE_NS   = 30,
  parameter int SHORT_RUN = 24,
  parameter int LONG_RUN  = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrDown,
  input  logic             newChan,
  input  logic             precSel,
  input  logic             errValid,
  input  logic [ERR_W-1:0] errNs,
  output logic             lockOut
);
  localparam int CNT_W = $clog2(LONG_RUN + 1);

  ldStrobes_t       stb;
  logic             isSmall;
  logic             isLarge;
  logic             runReached;
  logic [CNT_W-1:0] runCnt;

  lock_det_datapath #(
    .ERR_W(ERR_W), .ACQ_NS(ACQ_NS), .LOSE_NS(LOSE_NS),
    .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)
  ) uPath (
    .clk(clk), .rstN(rstN), .errNs(errNs), .precSel(precSel), .stb(stb),
    .isSmall(isSmall), .isLarge(isLarge), .runReached(runReached), .runCnt(runCnt)
  );

  lock_det_control uCtrl (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .newChan(newChan),
    .errValid(errValid), .isSmall(isSmall), .isLarge(isLarge),
    .runReached(runReached), .stb(stb), .lockQ(lockOut)
  );
endmodule

// File: rtl/pfd_lock_monitor_chk.sv
module pfd_lock_monitor_chk #(
  parameter int ERR_W    = 8,
  parameter int ACQ_NS   = 15,
  parameter int LOSE_NS  = 30,
  parameter int LONG_RUN = 40,
  localparam int CNT_W   = $clog2(LONG_RUN + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrDown,
  input logic             newChan,
  input logic             errValid,
  input logic [ERR_W-1:0] errNs,
  input logic             lockOut,
  input logic [CNT_W-1:0] runCnt
);
  AST_CHAN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    newChan |=> !lockOut); // R4
  AST_PWR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (!lockOut && runCnt == '0)); // R5
  AST_LARGE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && errValid && errNs > ERR_W'(LOSE_NS)) |=> !lockOut); // R3
  AST_MID_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && errValid && errNs <= ERR_W'(LOSE_NS) && !pwrDown && !newChan) |=> lockOut); // R6
  AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> $past(errValid && errNs < ERR_W'(ACQ_NS))); // R1
  AST_BIG_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (!lockOut && errValid && errNs >= ERR_W'(ACQ_NS)) |=> runCnt == '0); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!errValid && !pwrDown && !newChan) |=> ($stable(runCnt) && $stable(lockOut))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CNT_W'(LONG_RUN)); // R10
endmodule

bind pfd_lock_monitor pfd_lock_monitor_chk #(
  .ERR_W(ERR_W), .ACQ_NS(ACQ_NS), .LOSE_NS(LOSE_NS), .LONG_RUN(LONG_RUN)
) uChk (
  .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .newChan(newChan),
  .errValid(errValid), .errNs(errNs), .lockOut(lockOut), .runCnt(runCnt)
);

// File: tb/sim_pfd_lock_monitor.sv
`timescale 1ns/1ps
module sim_pfd_lock_monitor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrDown = 1'b0;
  logic       newChan = 1'b0;
  logic       precSel = 1'b0;
  logic       errValid = 1'b0;
  logic [7:0] errNs = '0;
  logic       lockOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pfd_lock_monitor u0 (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .newChan(newChan),
    .precSel(precSel), .errValid(errValid), .errNs(errNs), .lockOut(lockOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lockOut=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock with the given inputs; returns after the edge, at a falling edge.
  task automatic cyc(input logic v, input int e, input logic nc = 1'b0, input logic pd = 1'b0);
    errValid = v; errNs = 8'(e); newChan = nc; pwrDown = pd;
    @(negedge clk);
    errValid = 1'b0; newChan = 1'b0; pwrDown = 1'b0;
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 5);
  endtask

  task automatic t_acquire_short();
    precSel = 1'b0;
    goods(22); cyc(1'b1, 14);
    check("R2 short run minus one", lockOut, 1'b0);
    cyc(1'b1, 14);
    check("R1 R2 lock after 24 good (14 counts)", lockOut, 1'b1);
  endtask

  task automatic t_hysteresis();
    cyc(1'b1, 15); cyc(1'b1, 20); cyc(1'b1, 30);
    check("R6 errors 15..30 keep lock", lockOut, 1'b1);
    cyc(1'b1, 31);
    check("R3 error 31 drops lock", lockOut, 1'b0);
  endtask

  task automatic t_reacquire();
    goods(23);
    check("R8 23 good after loss", lockOut, 1'b0);
    goods(1);
    check("R8 full new run relocks", lockOut, 1'b1);
  endtask

  task automatic t_long_run();
    cyc(1'b0, 0, 1'b1);
    check("R4 newChan clears lock", lockOut, 1'b0);
    precSel = 1'b1;
    goods(39);
    check("R2 long run minus one", lockOut, 1'b0);
    goods(1);
    check("R2 lock after 40 good", lockOut, 1'b1);
    cyc(1'b0, 0, 1'b1);
    precSel = 1'b0;
  endtask

  task automatic t_broken_run();
    goods(10); cyc(1'b1, 15); goods(23);
    check("R1 R7 value 15 breaks run", lockOut, 1'b0);
    goods(1);
    check("R7 lock after fresh run", lockOut, 1'b1);
    cyc(1'b1, 200);
    check("R3 large error drops lock", lockOut, 1'b0);
  endtask

  task automatic t_idle_gaps();
    goods(12);
    for (int i = 0; i < 5; i++) cyc(1'b0, 99);
    goods(11);
    check("R9 idle cycles do not count", lockOut, 1'b0);
    goods(1);
    check("R9 idle cycles do not break run", lockOut, 1'b1);
  endtask

  task automatic t_power_down();
    cyc(1'b1, 5, 1'b0, 1'b1);
    check("R5 pwrDown clears lock", lockOut, 1'b0);
    for (int i = 0; i < 30; i++) cyc(1'b1, 5, 1'b0, 1'b1);
    check("R5 pwrDown holds lock low", lockOut, 1'b0);
    goods(23);
    check("R5 run zero after pwrDown", lockOut, 1'b0);
    goods(1);
    check("R5 relock after release", lockOut, 1'b1);
    cyc(1'b0, 0, 1'b1);
  endtask

  task automatic t_collision();
    goods(23);
    cyc(1'b1, 5, 1'b1);
    check("R4 newChan beats completing sample", lockOut, 1'b0);
    goods(23);
    check("R4 run cleared by newChan", lockOut, 1'b0);
    goods(1);
    check("R4 lock after full run", lockOut, 1'b1);
  endtask

  task automatic t_async_reset();
    #3 rstN = 1'b0;
    #2 check("R10 async reset clears lock", lockOut, 1'b0);
    @(negedge clk); rstN = 1'b1;
    goods(23);
    check("R10 reset cleared run", lockOut, 1'b0);
    goods(1);
    check("R10 lock after reset", lockOut, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", lockOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    t_acquire_short();
    t_hysteresis();
    t_reacquire();
    t_long_run();
    t_broken_run();
    t_idle_gaps();
    t_power_down();
    t_collision();
    t_async_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule